// File: doc/BRIEF.md
# Prime-Bank Modulo Address Mapper

This block turns a linear word address into a bank select and a word position inside that bank. The memory it serves has a prime number of banks, each holding a power-of-two number of words. The bank select is the address reduced modulo the bank count. The position inside the bank is the address reduced modulo the bank depth, which is simply its low bits. Because the two moduli share no factor, every address below the total capacity lands on its own (bank, position) pair. Strides that are powers of two therefore spread across all banks, and no divide by the bank count is needed.

Each address arrives with a qualifier. One cycle later the block presents a registered result. It can take a new address on every cycle. An address at or beyond the total capacity does not produce a mapping. Instead it raises an error flag for that one result slot. When the bank count is three, the modulo reduction is a tree of 2-bit digit sums. Any other odd prime uses a shift-and-subtract chain.

Top module: `prime_bank_mapper`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid and out_range_err are 0.
- R2: For a qualified address A below NUM_BANKS*BANK_DEPTH (24 by default), out_bank equals A mod NUM_BANKS.
- R3: For such an address, out_offset equals A mod BANK_DEPTH, which is the low log2(BANK_DEPTH) bits of A.
- R4: The result for an address qualified at clock edge k appears after edge k, with a latency of exactly one cycle. An address can be qualified on every cycle with no gaps.
- R5: A qualified address at or above NUM_BANKS*BANK_DEPTH gives out_range_err = 1 and out_valid = 0 on the next cycle.
- R6: Whenever out_valid is 0, both out_bank and out_offset are 0. This covers idle cycles, where in_valid is low, as well as out-of-range results.
- R7: Over all addresses from 0 to NUM_BANKS*BANK_DEPTH-1, the (out_bank, out_offset) pairs are all distinct and fill the whole bank-by-depth grid.
- R8: With the default 3 banks of 8 words, addresses 0, 16 and 8 map to offset 0 in banks 0, 1 and 2 respectively, and address 23 maps to bank 2, offset 7.
- R9: out_valid and out_range_err are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_addr on this edge |
| in_addr | input | ADDR_W | Linear word address |
| out_valid | output | 1 | Registered: mapping present |
| out_bank | output | BANK_W | Registered bank select |
| out_offset | output | OFF_W | Registered word position inside bank |
| out_range_err | output | 1 | Registered: last qualified address was out of range |

## Verification
On every busy cycle, the block presents the registered result of one address while it accepts the next one. That next address can be in range or out of range. The bench streams the entire address space back to back, so in-range results are followed directly by out-of-range ones. It also runs a pattern that alternates in-range, out-of-range and idle slots. Each cycle is compared against a model computed with a plain modulo operator. The model checks that a flag or mapping from one slot never leaks into the next slot.

// File: rtl/prime_bank_pkg.sv
package prime_bank_pkg;

   function automatic bit is_odd_prime(input int n);
      if (n < 3 || (n % 2) == 0) return 1'b0;
      for (int d = 3; d * d <= n; d += 2)
         if ((n % d) == 0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pm_residue.sv
module pm_residue #(
   parameter int ADDR_W = 5,
   parameter int MOD    = 3,
   parameter int RES_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [RES_W-1:0]  res
);
   generate
      if (MOD == 3) begin : g_fold
         localparam int DIG  = (ADDR_W + 1) / 2;
         localparam int SW   = $clog2(3 * DIG + 1) < 2 ? 2 : $clog2(3 * DIG + 1);
         localparam int SDIG = (SW + 1) / 2;
         logic [2*DIG-1:0]  ap;
         logic [SW-1:0]     acc;
         logic [2*SDIG-1:0] accp;
         always_comb begin
            ap  = (2*DIG)'(addr);
            acc = '0;
            for (int k = 0; k < DIG; k++)
               acc = acc + SW'(ap[2*k +: 2]);
            for (int f = 0; f < SW; f++) begin
               accp = (2*SDIG)'(acc);
               acc  = '0;
               for (int k = 0; k < SDIG; k++)
                  acc = acc + SW'(accp[2*k +: 2]);
            end
            res = (acc[1:0] == 2'd3) ? '0 : RES_W'(acc[1:0]);
         end
      end else begin : g_horner
         localparam int RW = RES_W;
         localparam logic [RW:0] MOD_V = (RW+1)'(MOD);
         logic [RW:0] r;
         always_comb begin
            r = '0;
            for (int i = ADDR_W - 1; i >= 0; i--) begin
               r = {r[RW-1:0], addr[i]};
               if (r >= MOD_V) r = r - MOD_V;
            end
            res = r[RW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/pm_range_check.sv
module pm_range_check #(
   parameter int ADDR_W = 5,
   parameter int TOTAL  = 24
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_range
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(TOTAL);
   assign in_range = ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/pm_out_stage.sv
module pm_out_stage #(
   parameter int BANK_W = 2,
   parameter int OFF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              reject,
   input  logic [BANK_W-1:0] bank_d,
   input  logic [OFF_W-1:0]  off_d,
   output logic              valid_q,
   output logic              err_q,
   output logic [BANK_W-1:0] bank_q,
   output logic [OFF_W-1:0]  off_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         bank_q  <= '0;
         off_q   <= '0;
      end else begin
         valid_q <= take;
         err_q   <= reject;
         bank_q  <= take ? bank_d : '0;
         off_q   <= take ? off_d  : '0;
      end
   end
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
   import prime_bank_pkg::*;
#(
   parameter int NUM_BANKS  = 3,
   parameter int BANK_DEPTH = 8,
   parameter int ADDR_W     = 5,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int OFF_W     = $clog2(BANK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic [BANK_W-1:0] out_bank,
   output logic [OFF_W-1:0]  out_offset,
   output logic              out_range_err
);
   localparam int TOTAL = NUM_BANKS * BANK_DEPTH;

   initial begin : p_param_chk
      if (!is_odd_prime(NUM_BANKS))
         $fatal(1, "NUM_BANKS must be an odd prime");
      if (!is_pow2(BANK_DEPTH))
         $fatal(1, "BANK_DEPTH must be a power of two above 1");
      if (ADDR_W < $clog2(TOTAL))
         $fatal(1, "ADDR_W too narrow for the bank grid");
   end

   logic [BANK_W-1:0] bank_c;
   logic              in_range;

   pm_residue #(.ADDR_W(ADDR_W), .MOD(NUM_BANKS), .RES_W(BANK_W)) u_residue (
      .addr (in_addr),
      .res  (bank_c)
   );

   pm_range_check #(.ADDR_W(ADDR_W), .TOTAL(TOTAL)) u_range (
      .addr     (in_addr),
      .in_range (in_range)
   );

   pm_out_stage #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (in_valid & in_range),
      .reject  (in_valid & ~in_range),
      .bank_d  (bank_c),
      .off_d   (in_addr[OFF_W-1:0]),
      .valid_q (out_valid),
      .err_q   (out_range_err),
      .bank_q  (out_bank),
      .off_q   (out_offset)
   );
endmodule

// File: rtl/prime_bank_mapper_chk.sv
module prime_bank_mapper_chk #(
   parameter int NUM_BANKS  = 3,
   parameter int BANK_DEPTH = 8,
   parameter int ADDR_W     = 5,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int OFF_W     = $clog2(BANK_DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_valid,
   input logic [BANK_W-1:0] out_bank,
   input logic [OFF_W-1:0]  out_offset,
   input logic              out_range_err
);
   localparam int TOTAL = NUM_BANKS * BANK_DEPTH;
   localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(TOTAL);
   logic ok_addr;
   assign ok_addr = ({1'b0, in_addr} < LIM);

   AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ok_addr |=> out_valid && !out_range_err); // R4
   AST_BANK_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ok_addr |=> 32'(out_bank) == (32'($past(in_addr)) % NUM_BANKS)); // R2
   AST_OFFSET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ok_addr |=> out_offset == $past(in_addr[OFF_W-1:0])); // R3
   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ok_addr |=> out_range_err && !out_valid); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_bank == '0 && out_offset == '0); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_range_err)); // R9
   AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_range_err); // R6
endmodule

bind prime_bank_mapper prime_bank_mapper_chk #(
   .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/prime_bank_mapper_bench.sv
module prime_bank_mapper_bench;
   localparam int NB = 3, BD = 8, AW = 5, TOT = NB * BD;
   localparam int BW = $clog2(NB), OW = $clog2(BD);

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic out_valid, out_range_err;
   logic [BW-1:0] out_bank;
   logic [OW-1:0] out_offset;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   int e_v = 0, e_e = 0, e_b = 0, e_o = 0;
   bit seen [TOT];

   always #2 clk = ~clk;

   prime_bank_mapper #(.NUM_BANKS(NB), .BANK_DEPTH(BD), .ADDR_W(AW)) u_prime_bank_mapper (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .out_valid(out_valid), .out_bank(out_bank), .out_offset(out_offset),
      .out_range_err(out_range_err));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_prev(input string req);
      chk(req, "out_valid", int'(out_valid), e_v);
      chk("R9", "out_range_err", int'(out_range_err), e_e);
      chk(req, "out_bank", int'(out_bank), e_b);
      chk(req, "out_offset", int'(out_offset), e_o);
   endtask

   // Check previous result at negedge, then present the next request.
   task automatic step(input bit v, input int a, input string req);
      @(negedge clk);
      check_prev(req);
      in_valid = v;
      in_addr  = AW'(a);
      e_v = (v && a < TOT) ? 1 : 0;
      e_e = (v && a >= TOT) ? 1 : 0;
      e_b = e_v ? a % NB : 0;
      e_o = e_v ? a % BD : 0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "out_range_err in reset", int'(out_range_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "out_valid after reset", int'(out_valid), 0);
      chk("R1", "out_range_err after reset", int'(out_range_err), 0);
   endtask

   task automatic t_examples;
      step(1, 0, "R8");
      step(1, 16, "R8");
      chk("R8", "addr0 bank", int'(out_bank), 0);
      chk("R8", "addr0 offset", int'(out_offset), 0);
      step(1, 8, "R8");
      chk("R8", "addr16 bank", int'(out_bank), 1);
      step(1, 23, "R8");
      chk("R8", "addr8 bank", int'(out_bank), 2);
      step(0, 0, "R8");
      chk("R8", "addr23 bank", int'(out_bank), 2);
      chk("R8", "addr23 offset", int'(out_offset), 7);
   endtask

   // Back-to-back over every address: R2 R3 R4 R5, and R7 collection.
   task automatic t_sweep;
      for (int i = 0; i < TOT; i++) seen[i] = 1'b0;
      for (int a = 0; a < (1 << AW); a++) begin
         step(1, a, (a - 1 >= TOT) ? "R5" : "R4");
         if (out_valid && a > 0) begin
            chk("R2", "sweep bank", int'(out_bank), (a - 1) % NB);
            chk("R3", "sweep offset", int'(out_offset), (a - 1) % BD);
            chk("R7", "duplicate pair", int'(seen[int'(out_bank) * BD + int'(out_offset)]), 0);
            seen[int'(out_bank) * BD + int'(out_offset)] = 1'b1;
         end
      end
      step(0, 0, "R5");
      begin
         int cnt = 0;
         for (int i = 0; i < TOT; i++) cnt += int'(seen[i]);
         chk("R7", "grid cells covered", cnt, TOT);
      end
   endtask

   // Alternating in-range / out-of-range / idle slots: R5 R6 R9.
   task automatic t_mixed;
      step(1, 5, "R2");
      step(1, 30, "R2");
      step(0, 7, "R5");
      chk("R5", "err after 30", int'(out_range_err), 1);
      step(1, 24, "R6");
      chk("R6", "idle bank zero", int'(out_bank), 0);
      step(1, 19, "R5");
      step(1, 31, "R3");
      step(0, 31, "R5");
      step(0, 0, "R6");
      chk("R6", "idle valid", int'(out_valid), 0);
      chk("R6", "idle err", int'(out_range_err), 0);
      step(0, 0, "R6");
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_examples();
      t_sweep();
      t_mixed();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule